// File: doc/BRIEF.md
# Noise-Shaping Word-Length Requantizer

This block takes one 14-bit two's-complement converter sample per clock and turns it into a shorter signed word. Before each sample is rounded, a correction is subtracted from it. The correction is a weighted sum of the rounding errors left by the preceding samples. Because of this error feedback, the quantization noise moves out of a chosen frequency band. The in-band signal-to-noise ratio therefore stays close to what the full input width gives, even though far fewer bits are kept. The feedback sum is taken from registered error history and combined with the incoming sample in the same cycle. The block adds no latency inside the loop and keeps a rate of one sample per clock.

A two-bit mode input chooses the output width and the feedback weights. Mode 0 keeps 11 bits with a double noise zero at DC. Modes 1 and 2 keep 9 bits with a resonant zero pair in a band below and above quarter rate respectively. Mode 3 keeps 6 bits and places zero pairs at one sixth and one third of the sample rate, which protects two passbands at once.

A small controller tracks whether the error history is valid. Its states are ST_EMPTY (the history is all zero, after reset or after a flush) and ST_ACTIVE (the history holds errors of the current mode). It has three transitions. LOAD goes from ST_EMPTY to ST_ACTIVE on an accepted sample. FLUSH goes from ST_ACTIVE to ST_EMPTY when the mode changes in a cycle with no sample. RESEED keeps ST_ACTIVE when the mode changes in the same cycle as a sample: that sample sees no feedback and starts a fresh history.

Top module: `nsq_requant`

## Requirements
- R1: A synchronous reset drives out_valid and out_data to zero and empties the error history. The first sample after reset is therefore rounded with zero correction.
- R2: A sample accepted with in_valid high at one rising edge appears on out_data with out_valid high after that edge. out_valid is the input qualifier delayed by exactly one clock.
- R3: The output width W is 11, 9, 9 and 6 bits for modes 0, 1, 2 and 3. With S = 14 - W, the output code is floor((v + 2^(S-1)) / 2^S), where v is the corrected sample. The code is presented sign-extended on the 11-bit out_data.
- R4: The output code is clamped to the range -2^(W-1) to 2^(W-1)-1 of the active mode.
- R5: The error stored for each accepted sample is code*2^S - v, clipped to the range -2^(S-1) to +2^(S-1).
- R6: The corrected sample is v = x - floor(A / 4), where A = sum over k=1..4 of c_k * e[n-k], and e[n-k] is the stored error of the k-th previous accepted sample. The weights c_1..c_4, in quarters, are mode 0: 8,-4,0,0; mode 1: 6,-4,0,0; mode 2: -6,-4,0,0; mode 3: 0,-4,0,-4. The correction comes from history alone and applies to the sample of the same cycle.
- R7: In a cycle with in_valid low, out_valid goes low on the next edge, out_data keeps its last value and the error history does not advance.
- R8: The history is cleared whenever in_mode differs from its value at the previous clock. This happens both when the mode changes with no sample (FLUSH) and when it changes together with a sample, which is then processed with zero correction (RESEED).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is present on in_data |
| in_mode | input | 2 | Operating mode select (0..3) |
| in_data | input | 14 | Signed input sample |
| out_valid | output | 1 | out_data holds a new code |
| out_data | output | 11 | Signed requantized code, sign-extended |

## Verification
The hardest cases to reach are those where the stored error differs from the plain rounding residue. This happens when the output saturates and the error is clipped, and when a mode change arrives in the same cycle as a sample (RESEED) rather than in an idle cycle (FLUSH). The stimulus drives full-scale positive and negative samples in the 6-bit mode so that the clamp and the error clip are both hit. It switches mode on a valid sample with values chosen so that a stale history would change the output code. It also switches mode during idle gaps. A long random sweep with random gaps and mode changes then compares every output against an independent model of the arithmetic.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

    localparam int IN_W    = 14;            // input sample width
    localparam int OUT_MAX = 11;            // widest output code
    localparam int MODE_W  = 2;             // mode select width
    localparam int NTAP    = 4;             // error feedback taps
    localparam int CW      = 5;             // coefficient width (signed)
    localparam int CFRAC   = 2;             // coefficient fractional bits
    localparam int VW      = IN_W + 3;      // corrected sample width
    localparam int EW      = VW + 1;        // stored error width
    localparam int AW      = EW + CW + 2;   // feedback accumulator width

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_ACTIVE = 1'b1
    } nsq_state_t;

    // output code width per mode
    function automatic int mode_out_w(input logic [MODE_W-1:0] m);
        unique case (m)
            2'd0:    return 11;
            2'd1:    return 9;
            2'd2:    return 9;
            default: return 6;
        endcase
    endfunction

    // feedback weight of tap k (k=0 is the newest error), in quarters
    function automatic logic signed [CW-1:0] mode_coef(input logic [MODE_W-1:0] m,
                                                       input int k);
        logic signed [CW-1:0] c;
        c = '0;
        unique case (m)
            2'd0: begin
                if (k == 0) c = 5'sd8;
                if (k == 1) c = -5'sd4;
            end
            2'd1: begin
                if (k == 0) c = 5'sd6;
                if (k == 1) c = -5'sd4;
            end
            2'd2: begin
                if (k == 0) c = -5'sd6;
                if (k == 1) c = -5'sd4;
            end
            default: begin
                if (k == 1) c = -5'sd4;
                if (k == 3) c = -5'sd4;
            end
        endcase
        return c;
    endfunction

    // code lies inside the range of the mode's width
    function automatic logic out_fits(input logic signed [OUT_MAX-1:0] y,
                                      input logic [MODE_W-1:0] m);
        int w;
        int yi;
        w  = mode_out_w(m);
        yi = int'(y);
        return (yi <= (1 << (w - 1)) - 1) && (yi >= -(1 << (w - 1)));
    endfunction

    // stored error lies within half an output step
    function automatic logic err_fits(input logic signed [EW-1:0] e,
                                      input logic [MODE_W-1:0] m);
        int half;
        int ei;
        half = 1 << (IN_W - mode_out_w(m) - 1);
        ei   = int'(e);
        return (ei <= half) && (ei >= -half);
    endfunction

endpackage

// File: rtl/nsq_fb_fir.sv
module nsq_fb_fir
    import nsq_pkg::*;
#(
    parameter int P_NTAP  = NTAP,
    parameter int P_EW    = EW,
    parameter int P_AW    = AW,
    parameter int P_VW    = VW,
    parameter int P_CFRAC = CFRAC
) (
    input  logic [MODE_W-1:0]            mode,
    input  logic [P_NTAP-1:0][P_EW-1:0]  hist,
    output logic signed [P_VW-1:0]       fb
);

    logic signed [P_AW-1:0] prod [P_NTAP];
    logic signed [P_AW-1:0] acc;

    // one constant-weight product per tap; weights are small, so each
    // collapses to a few shifted adds
    for (genvar k = 0; k < P_NTAP; k++) begin : g_tap
        assign prod[k] = P_AW'(mode_coef(mode, k)) * P_AW'($signed(hist[k]));
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < P_NTAP; k++) begin
            acc = acc + prod[k];
        end
        fb = P_VW'(acc >>> P_CFRAC);
    end

endmodule

// File: rtl/nsq_quant.sv
module nsq_quant
    import nsq_pkg::*;
#(
    parameter int P_IN_W    = IN_W,
    parameter int P_VW      = VW,
    parameter int P_OUT_MAX = OUT_MAX,
    parameter int P_EW      = EW
) (
    input  logic [MODE_W-1:0]           mode,
    input  logic signed [P_VW-1:0]      v,
    output logic signed [P_OUT_MAX-1:0] y,
    output logic signed [P_EW-1:0]      e
);

    localparam int XW = P_VW + 1;

    int                    w;
    int                    sh;
    logic signed [XW-1:0]  vx;
    logic signed [XW-1:0]  half;
    logic signed [XW-1:0]  rnd;
    logic signed [XW-1:0]  hi;
    logic signed [XW-1:0]  lo;
    logic signed [XW-1:0]  ysat;
    logic signed [XW-1:0]  err;

    always_comb begin
        w    = mode_out_w(mode);
        sh   = P_IN_W - w;
        vx   = XW'(v);
        half = XW'(1) <<< (sh - 1);
        hi   = XW'((1 << (w - 1)) - 1);
        lo   = XW'(-(1 << (w - 1)));
        // round half up to the mode's step
        rnd  = (vx + half) >>> sh;
        if (rnd > hi) begin
            ysat = hi;
        end else if (rnd < lo) begin
            ysat = lo;
        end else begin
            ysat = rnd;
        end
        // residue at input weight, clipped so a clamp cannot pump the loop
        err = (ysat <<< sh) - vx;
        if (err > half) begin
            err = half;
        end else if (err < -half) begin
            err = -half;
        end
        y = P_OUT_MAX'(ysat);
        e = P_EW'(err);
    end

endmodule

// File: rtl/nsq_ctrl.sv
module nsq_ctrl
    import nsq_pkg::*;
#(
    parameter int P_NTAP = NTAP,
    parameter int P_EW   = EW
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [MODE_W-1:0]            mode,
    input  logic signed [P_EW-1:0]       e_new,
    output logic [P_NTAP-1:0][P_EW-1:0]  hist_eff
);

    nsq_state_t                  state;
    nsq_state_t                  nxt;
    logic [MODE_W-1:0]           mode_q;
    logic [P_NTAP-1:0][P_EW-1:0] hist;
    logic                        mode_chg;

    assign mode_chg = (mode != mode_q);

    // next-state decode: LOAD, FLUSH, RESEED
    always_comb begin
        nxt = state;
        unique case (state)
            ST_EMPTY: begin
                if (in_valid) nxt = ST_ACTIVE;               // LOAD
            end
            ST_ACTIVE: begin
                if (!in_valid && mode_chg) nxt = ST_EMPTY;   // FLUSH
                else                       nxt = ST_ACTIVE;  // hold / RESEED
            end
        endcase
    end

    // state register and error delay line
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_EMPTY;
            mode_q <= '0;
            hist   <= '0;
        end else begin
            state  <= nxt;
            mode_q <= mode;
            if (in_valid) begin
                hist <= {hist_eff[P_NTAP-2:0], e_new};
            end else if (nxt == ST_EMPTY) begin
                hist <= '0;
            end
        end
    end

    // history seen by the loop: only when it belongs to this mode
    always_comb begin
        if (state == ST_ACTIVE && !mode_chg) hist_eff = hist;
        else                                 hist_eff = '0;
    end

    // R5
    err_clip_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> err_fits($signed(hist[0]), $past(mode)));

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && mode_chg) |=> (state == ST_EMPTY && hist == '0));

endmodule

// File: rtl/nsq_requant.sv
module nsq_requant
    import nsq_pkg::*;
#(
    parameter int P_IN_W    = IN_W,
    parameter int P_OUT_MAX = OUT_MAX,
    parameter int P_NTAP    = NTAP
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [MODE_W-1:0]           in_mode,
    input  logic signed [P_IN_W-1:0]    in_data,
    output logic                        out_valid,
    output logic signed [P_OUT_MAX-1:0] out_data
);

    logic [P_NTAP-1:0][EW-1:0]   hist_eff;
    logic signed [VW-1:0]        fb;
    logic signed [VW-1:0]        v;
    logic signed [P_OUT_MAX-1:0] y;
    logic signed [EW-1:0]        e_new;

    nsq_fb_fir #(.P_NTAP(P_NTAP)) u_fir (
        .mode (in_mode),
        .hist (hist_eff),
        .fb   (fb)
    );

    // same-cycle correction: no register between history and quantizer
    assign v = VW'(in_data) - fb;

    nsq_quant #(.P_IN_W(P_IN_W), .P_OUT_MAX(P_OUT_MAX)) u_quant (
        .mode (in_mode),
        .v    (v),
        .y    (y),
        .e    (e_new)
    );

    nsq_ctrl #(.P_NTAP(P_NTAP)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .mode     (in_mode),
        .e_new    (e_new),
        .hist_eff (hist_eff)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= y;
        end
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R4
    range_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_fits(out_data, $past(in_mode)));

endmodule

// File: tb/nsq_requant_tb.sv
`timescale 1ns/1ps
module nsq_requant_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [1:0]        in_mode = 2'd0;
    logic signed [13:0] in_data = '0;
    logic              out_valid;
    logic signed [10:0] out_data;

    always #2 clk = ~clk;

    nsq_requant u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    typedef struct {
        bit    vld;
        int    data;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    int m_hist[4];
    int m_prev = 0;
    int m_last = 0;

    // weights in quarters, per requirement R6
    function automatic int wq(input int m, input int k);
        case (m)
            0: return (k == 0) ? 8  : (k == 1) ? -4 : 0;
            1: return (k == 0) ? 6  : (k == 1) ? -4 : 0;
            2: return (k == 0) ? -6 : (k == 1) ? -4 : 0;
            default: return (k == 1 || k == 3) ? -4 : 0;
        endcase
    endfunction

    function automatic int wid(input int m);
        return (m == 0) ? 11 : (m == 3) ? 6 : 9;
    endfunction

    task automatic drive(input int x, input int m, input bit v, input string tag);
        int acc, vv, sh, half, r, hi, lo, er;
        @(negedge clk);
        in_data  = 14'(x);
        in_mode  = 2'(m);
        in_valid = v;
        if (m != m_prev) begin
            for (int k = 0; k < 4; k++) m_hist[k] = 0;
        end
        m_prev = m;
        if (v) begin
            acc = 0;
            for (int k = 0; k < 4; k++) acc += wq(m, k) * m_hist[k];
            vv   = x - (acc >>> 2);
            sh   = 14 - wid(m);
            half = 1 << (sh - 1);
            hi   = (1 << (wid(m) - 1)) - 1;
            lo   = -(1 << (wid(m) - 1));
            r    = (vv + half) >>> sh;
            if (r > hi) r = hi;
            if (r < lo) r = lo;
            er = r * (1 << sh) - vv;
            if (er > half)  er = half;
            if (er < -half) er = -half;
            for (int k = 3; k > 0; k--) m_hist[k] = m_hist[k-1];
            m_hist[0] = er;
            m_last = r;
            sb.push_back('{1'b1, r, tag});
        end else begin
            sb.push_back('{1'b0, m_last, tag});
        end
    endtask

    // monitor: one expected item per cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on && sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                n_chk++;
                if (out_valid !== it.vld) begin
                    n_bad++;
                    $display("FAIL R2 (%s) out_valid=%0b expected=%0b", it.tag, out_valid, it.vld);
                end
                n_chk++;
                if (int'(out_data) !== it.data) begin
                    n_bad++;
                    if (it.vld)
                        $display("FAIL %s out_data=%0d expected=%0d", it.tag, int'(out_data), it.data);
                    else
                        $display("FAIL R7 (%s) held out_data=%0d expected=%0d", it.tag, int'(out_data), it.data);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) m_hist[k] = 0;
        // R1: samples offered during reset must leave nothing behind
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 14'sd1000;
        in_mode  = 2'd2;
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_bad++;
            $display("FAIL R1 out_valid=%0b out_data=%0d expected 0/0", out_valid, int'(out_data));
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_mode  = 2'd0;
        rst      = 1'b0;
        m_prev   = 0;
        m_last   = 0;
        mon_on   = 1'b1;

        // R1 + R6: first sample sees zero correction, second sees the error
        drive(5, 0, 1'b1, "R1");
        drive(5, 0, 1'b1, "R6");
        drive(5, 0, 1'b1, "R6");
        // R3: ramp in the 11-bit mode, both signs
        for (int i = -40; i <= 40; i += 7) drive(i * 37, 0, 1'b1, "R3");
        // R7: idle gap keeps the output and history
        drive(123, 0, 1'b0, "R7");
        drive(-999, 0, 1'b0, "R7");
        drive(77, 0, 1'b1, "R7");
        // R8: RESEED: mode change on a sample
        drive(5, 0, 1'b1, "R8");
        drive(17, 1, 1'b1, "R8");
        drive(300, 1, 1'b1, "R6");
        drive(-300, 2, 1'b1, "R8");
        drive(-300, 2, 1'b1, "R6");
        // R8: FLUSH: mode change during idle
        drive(0, 1, 1'b0, "R8");
        drive(0, 2, 1'b0, "R8");
        drive(1111, 2, 1'b1, "R8");
        // R4 + R5: full scale in the 6-bit mode
        drive(8191, 3, 1'b1, "R4");
        drive(8191, 3, 1'b1, "R5");
        drive(-8192, 3, 1'b1, "R4");
        drive(-8192, 3, 1'b1, "R5");
        drive(4000, 3, 1'b1, "R5");
        drive(8191, 0, 1'b1, "R4");
        drive(-8192, 1, 1'b1, "R4");
        // R6: dual-band mode on a small tone-like pattern
        for (int i = 0; i < 24; i++) drive((i % 6) * 700 - 1750, 3, 1'b1, "R6");
        // R6: random sweep with gaps and mode changes
        begin
            int md;
            md = 0;
            for (int i = 0; i < 600; i++) begin
                if ($urandom_range(0, 40) == 0) md = $urandom_range(0, 3);
                drive(int'($urandom_range(0, 16383)) - 8192, md,
                      ($urandom_range(0, 4) != 0), "R6");
            end
        end
        drive(0, 0, 1'b0, "R7");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule